// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Interrupts

This block is the register front end and interrupt logic for one bank of general-purpose I/O pins, organised as four ports of eight pins. Software reaches it through a simple synchronous register interface (address, write strobe, write data, combinational read data). Through it, software selects GPIO mode per pin, sets output values and output enables, and reads back the synchronised pin levels.

Each pin has its own interrupt trigger type. The choices are rising edge, falling edge, either edge, high level and low level. Pins that have seen their event hold a status bit. Status ANDed with a per-pin enable is ORed across the bank onto one interrupt line.

A second aliased register window performs masked per-pin writes. Software can change one pin's setting without a read-modify-write sequence, so code serving different pins of the same port cannot race.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the config, output-enable, output, interrupt-enable and trigger-type registers of every port are zero: `pin_gpio_sel`, `pin_oe` and `pin_out` are all zero and `bank_irq` is low.
- R2: Address decoding:
  - Bits [6:4] select the register group: 0 config, 1 output enable, 2 output, 3 input, 4 status, 5 enable, 6 trigger type, 7 clear.
  - Bits [3:2] select the port. Bits [10:7] must be zero.
  - Reads of config, output enable, output, status, enable and type return the stored value. Clear reads as zero.
  - Port p drives bits [8p+7:8p] of `pin_gpio_sel`, `pin_oe` and `pin_out`.
- R3: Masked window:
  - Address bit 11 set selects the masked window. A write there treats data bits [15:8] as a per-pin mask and bits [7:0] as the new values, and changes only the masked pins.
  - For the type group, only type bits [7:0] are updated.
  - Masked writes to the input and clear groups have no effect.
- R4: The input group returns `pin_in` after a two-flop synchronizer: a change made before clock edge k reads back after edge k+1, and not after edge k alone.
- R5: The type register of a port holds pin n's polarity in bit n, its edge select in bit n+8 and its both-edge select in bit n+16:
  - 0x000101 per pin is rising edge.
  - 0x000100 is falling edge.
  - 0x010100 is either edge.
  - An edge-type pin sets its status only on the selected transition.
- R6: For a level-type pin (edge select clear), status follows the active level: high when the polarity bit is set, low when it is clear. A clear write does not remove it while the level stays active.
- R7: Writing the clear group drops the status of every edge-type pin whose data bit is 1. Pins with a 0 data bit keep their status.
- R8: `bank_irq` is high exactly when some pin has both its status and its enable bit set. A pin with enable clear never raises it.
- R9: Edge status is sticky until cleared. An edge detected in the same cycle as a clear write for that pin leaves the status set.
- R10: A write to the status group loads edge-type status bits directly (masked in the alias window).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| pin_gpio_sel | output | 32 | Per-pin GPIO mode select |
| bank_irq | output | 1 | Bank interrupt request |

## Verification
The hardest situation to reach is a new edge that lands in the very cycle a clear write for the same pin is captured. That cycle lies two clock edges after the pin moves, behind the synchronizer and the previous-value flop.

The stimulus changes the pin on a falling clock edge. It waits exactly two rising edges and then issues the clear, so that the capture edge coincides with edge detection. The expected status is then set, not cleared.

Random masked and direct writes across the configuration groups are mixed with directed runs through every trigger type. These runs exercise the alias window's per-bit merge and each type's status behaviour.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

    // register group selected by address bits [6:4]
    typedef enum logic [2:0] {
        GRP_CFG = 3'd0,
        GRP_OE  = 3'd1,
        GRP_OUT = 3'd2,
        GRP_IN  = 3'd3,
        GRP_STA = 3'd4,
        GRP_ENB = 3'd5,
        GRP_TYP = 3'd6,
        GRP_CLR = 3'd7
    } grp_e;

    localparam int MASK_BIT = 11;   // alias window select
    localparam int GRP_LSB  = 4;
    localparam int PORT_LSB = 2;

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] lvl_cur,
    output logic [W-1:0] lvl_prev
);

    logic [W-1:0] meta_q;

    // two synchronizing flops plus one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            lvl_cur  <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= raw_in;
            lvl_cur  <= meta_q;
            lvl_prev <= lvl_cur;
        end
    end

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  grp_e              wr_grp,
    input  logic              wr_masked,
    input  logic [3*PINS-1:0] wr_data,
    input  logic [PINS-1:0]   lvl_cur,
    input  logic [PINS-1:0]   lvl_prev,
    output logic [PINS-1:0]   cfg_q,
    output logic [PINS-1:0]   oe_q,
    output logic [PINS-1:0]   out_q,
    output logic [PINS-1:0]   sta_q,
    output logic [PINS-1:0]   enb_q,
    output logic [3*PINS-1:0] typ_q,
    output logic              irq_req
);

    localparam int TW = 3 * PINS;

    logic [PINS-1:0] wmask, wval;
    assign wmask = wr_data[2*PINS-1:PINS];
    assign wval  = wr_data[PINS-1:0];

    function automatic logic [PINS-1:0] merge(input logic [PINS-1:0] old,
                                              input logic [PINS-1:0] m,
                                              input logic [PINS-1:0] v,
                                              input logic            masked);
        return masked ? ((old & ~m) | (v & m)) : v;
    endfunction

    logic wr_cfg, wr_oe, wr_out, wr_sta, wr_enb, wr_typ, wr_clr;
    assign wr_cfg = wr_hit && (wr_grp == GRP_CFG);
    assign wr_oe  = wr_hit && (wr_grp == GRP_OE);
    assign wr_out = wr_hit && (wr_grp == GRP_OUT);
    assign wr_sta = wr_hit && (wr_grp == GRP_STA);
    assign wr_enb = wr_hit && (wr_grp == GRP_ENB);
    assign wr_typ = wr_hit && (wr_grp == GRP_TYP);
    assign wr_clr = wr_hit && (wr_grp == GRP_CLR) && !wr_masked;

    // status after software action, before this cycle's events
    logic [PINS-1:0] sta_base, sta_d;
    always_comb begin
        sta_base = sta_q;
        if (wr_clr) sta_base = sta_q & ~wval;
        if (wr_sta) sta_base = merge(sta_q, wmask, wval, wr_masked);
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic pol, edg, both, rise, fall, ev, act;
        assign pol  = typ_q[i];
        assign edg  = typ_q[PINS + i];
        assign both = typ_q[2*PINS + i];
        assign rise = lvl_cur[i] & ~lvl_prev[i];
        assign fall = ~lvl_cur[i] & lvl_prev[i];
        assign ev   = edg & (both ? (rise | fall) : (pol ? rise : fall));
        assign act  = (lvl_cur[i] == pol);
        // edge pins: sticky, a new event outranks a clear; level pins track
        assign sta_d[i] = edg ? (sta_base[i] | ev) : act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            oe_q  <= '0;
            out_q <= '0;
            sta_q <= '0;
            enb_q <= '0;
            typ_q <= '0;
        end else begin
            if (wr_cfg) cfg_q <= merge(cfg_q, wmask, wval, wr_masked);
            if (wr_oe)  oe_q  <= merge(oe_q,  wmask, wval, wr_masked);
            if (wr_out) out_q <= merge(out_q, wmask, wval, wr_masked);
            if (wr_enb) enb_q <= merge(enb_q, wmask, wval, wr_masked);
            if (wr_typ) begin
                if (wr_masked)
                    typ_q[PINS-1:0] <= merge(typ_q[PINS-1:0], wmask, wval, 1'b1);
                else
                    typ_q <= wr_data[TW-1:0];
            end
            sta_q <= sta_d;
        end
    end

    assign irq_req = |(sta_q & enb_q);

endmodule

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PINS      = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [NUM_PORTS*PINS-1:0] pin_in,
    output logic [NUM_PORTS*PINS-1:0] pin_out,
    output logic [NUM_PORTS*PINS-1:0] pin_oe,
    output logic [NUM_PORTS*PINS-1:0] pin_gpio_sel,
    output logic                      bank_irq
);

    localparam int W       = NUM_PORTS * PINS;
    localparam int TW      = 3 * PINS;
    localparam int PORT_AW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    // address decode
    grp_e               grp;
    logic [PORT_AW-1:0] port_idx;
    logic               addr_ok, masked;
    assign grp      = grp_e'(bus_addr[GRP_LSB +: 3]);
    assign port_idx = bus_addr[PORT_LSB +: PORT_AW];
    assign masked   = bus_addr[MASK_BIT];
    assign addr_ok  = (bus_addr[MASK_BIT-1:GRP_LSB+3] == '0)
                    && (int'(port_idx) < NUM_PORTS);

    logic unused_bits;
    assign unused_bits = &{1'b0, bus_addr[PORT_LSB-1:0], bus_wdata[DATA_W-1:TW]};

    // input synchronizer
    logic [W-1:0] lvl_cur, lvl_prev;
    gpio_in_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  (pin_in),
        .lvl_cur (lvl_cur),
        .lvl_prev(lvl_prev)
    );

    logic [NUM_PORTS-1:0][PINS-1:0] cfg_a, oe_a, out_a, sta_a, enb_a;
    logic [NUM_PORTS-1:0][TW-1:0]   typ_a;
    logic [NUM_PORTS-1:0]           irq_a;
    logic [W-1:0]                   sta_all, enb_all, edge_all;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = bus_we && addr_ok && (int'(port_idx) == p);
        gpio_port #(.PINS(PINS)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit),
            .wr_grp   (grp),
            .wr_masked(masked),
            .wr_data  (bus_wdata[TW-1:0]),
            .lvl_cur  (lvl_cur[p*PINS +: PINS]),
            .lvl_prev (lvl_prev[p*PINS +: PINS]),
            .cfg_q    (cfg_a[p]),
            .oe_q     (oe_a[p]),
            .out_q    (out_a[p]),
            .sta_q    (sta_a[p]),
            .enb_q    (enb_a[p]),
            .typ_q    (typ_a[p]),
            .irq_req  (irq_a[p])
        );
        assign edge_all[p*PINS +: PINS] = typ_a[p][2*PINS-1:PINS];
    end

    assign sta_all      = sta_a;
    assign enb_all      = enb_a;
    assign pin_gpio_sel = cfg_a;
    assign pin_oe       = oe_a;
    assign pin_out      = out_a;
    assign bank_irq     = |irq_a;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            case (grp)
                GRP_CFG: bus_rdata = DATA_W'(cfg_a[port_idx]);
                GRP_OE:  bus_rdata = DATA_W'(oe_a[port_idx]);
                GRP_OUT: bus_rdata = DATA_W'(out_a[port_idx]);
                GRP_IN:  bus_rdata = DATA_W'(lvl_cur[port_idx*PINS +: PINS]);
                GRP_STA: bus_rdata = DATA_W'(sta_a[port_idx]);
                GRP_ENB: bus_rdata = DATA_W'(enb_a[port_idx]);
                GRP_TYP: bus_rdata = DATA_W'(typ_a[port_idx]);
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
#(
    parameter int W      = 32,
    parameter int PINS   = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pin_oe,
    input logic              bank_irq,
    input logic [W-1:0]      sta_all,
    input logic [W-1:0]      enb_all,
    input logic [W-1:0]      edge_all
);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> (pin_oe == '0 && pin_out == '0 && !bank_irq)); // R1

    AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[MASK_BIT] && bus_addr[GRP_LSB +: 3] == 3'(GRP_OE)
         && bus_wdata[2*PINS-1:PINS] == '0) |=> $stable(pin_oe)); // R3

    AST_CLEAR_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_addr[MASK_BIT] && bus_addr[GRP_LSB +: 3] == 3'(GRP_CLR)
         && bus_wdata[PINS-1:0] == '0)
        |=> (($past(sta_all) & $past(edge_all) & ~sta_all) == '0)); // R7

    AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (enb_all == '0) |-> !bank_irq); // R8

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> (($past(sta_all) & $past(edge_all) & ~sta_all) == '0)); // R9

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
    .W(W), .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .bank_irq (bank_irq),
    .sta_all  (sta_all),
    .enb_all  (enb_all),
    .edge_all (edge_all)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] pin_in, pin_out, pin_oe, pin_gpio_sel;
    logic        bank_irq;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_gpio_sel(pin_gpio_sel),
        .bank_irq(bank_irq)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] ad(input int grp, input int port, input bit m);
        return 12'((m ? 2048 : 0) + grp * 16 + port * 4);
    endfunction

    function automatic logic [7:0] mrg(input logic [7:0] old, input logic [15:0] d);
        return (old & ~d[15:8]) | (d[7:0] & d[15:8]);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic setpin(input int bitpos, input logic v);
        @(negedge clk);
        pin_in[bitpos] = v;
    endtask

    // bench model of the configuration registers
    logic [7:0]  m_cfg [4];
    logic [7:0]  m_oe  [4];
    logic [7:0]  m_out [4];
    logic [23:0] m_typ [4];

    function automatic logic [31:0] flat(input logic [7:0] a [4]);
        return {a[3], a[2], a[1], a[0]};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] seed_val;
        rst_n = 1'b0; pin_in = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        seed_val = $urandom(32'h00C0FFEE);
        for (int p = 0; p < 4; p++) begin
            m_cfg[p] = '0; m_oe[p] = '0; m_out[p] = '0; m_typ[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 out", pin_out, 32'h0);
        chk("R1 sel", pin_gpio_sel, 32'h0);
        chk("R1 irq", {31'h0, bank_irq}, 32'h0);
        rd(ad(6, 2, 0), d); chk("R1 type", d, 32'h0);
        rd(ad(5, 1, 0), d); chk("R1 enable", d, 32'h0);

        // R2/R3 random direct and masked writes
        for (int n = 0; n < 150; n++) begin
            int g, p;
            bit m;
            logic [31:0] r;
            int gsel;
            gsel = int'($urandom % 4);
            g = (gsel == 3) ? 6 : gsel;
            p = int'($urandom % 4);
            m = 1'($urandom % 2);
            r = $urandom ^ seed_val;
            wr(ad(g, p, m), r);
            case (g)
                0: m_cfg[p] = m ? mrg(m_cfg[p], r[15:0]) : r[7:0];
                1: m_oe[p]  = m ? mrg(m_oe[p],  r[15:0]) : r[7:0];
                2: m_out[p] = m ? mrg(m_out[p], r[15:0]) : r[7:0];
                default: m_typ[p] = m ? {m_typ[p][23:8], mrg(m_typ[p][7:0], r[15:0])} : r[23:0];
            endcase
            rd(ad(g, p, 0), d);
            case (g)
                0: chk(m ? "R3 cfg" : "R2 cfg", d, {24'h0, m_cfg[p]});
                1: chk(m ? "R3 oe" : "R2 oe", d, {24'h0, m_oe[p]});
                2: chk(m ? "R3 out" : "R2 out", d, {24'h0, m_out[p]});
                default: chk(m ? "R3 type" : "R2 type", d, {8'h0, m_typ[p]});
            endcase
            chk("R2 pin_gpio_sel", pin_gpio_sel, flat(m_cfg));
            chk("R2 pin_oe", pin_oe, flat(m_oe));
            chk("R2 pin_out", pin_out, flat(m_out));
            chk("R8 irq with enables clear", {31'h0, bank_irq}, 32'h0);
        end
        for (int p = 0; p < 4; p++) wr(ad(6, p, 0), 32'h0);

        // R4 synchronizer latency
        @(negedge clk);
        pin_in = 32'h5A3C_96E1;
        rd(ad(3, 1, 0), d); chk("R4 input after one edge", d, 32'h0);
        rd(ad(3, 1, 0), d); chk("R4 input after two edges", d, 32'h96);
        rd(ad(3, 3, 0), d); chk("R4 input port3", d, 32'h5A);
        @(negedge clk); pin_in = '0;
        settle();

        // R5 rising edge, port1 pin3 (bit 11)
        wr(ad(6, 1, 0), 32'h000808);
        wr(ad(5, 1, 0), 32'h08);
        wr(ad(7, 1, 0), 32'hFF);
        settle();
        rd(ad(4, 1, 0), d); chk("R5 rising idle", d & 32'h8, 32'h0);
        chk("R8 irq idle", {31'h0, bank_irq}, 32'h0);
        setpin(11, 1'b1); settle();
        rd(ad(4, 1, 0), d); chk("R5 rising set", d & 32'h8, 32'h8);
        chk("R8 irq on", {31'h0, bank_irq}, 32'h1);
        setpin(11, 1'b0); settle();
        rd(ad(4, 1, 0), d); chk("R9 sticky after fall", d & 32'h8, 32'h8);
        wr(ad(7, 1, 0), 32'hF7); settle();
        rd(ad(4, 1, 0), d); chk("R7 zero bit keeps", d & 32'h8, 32'h8);
        wr(ad(7, 1, 0), 32'h08);
        rd(ad(4, 1, 0), d); chk("R7 one bit clears", d & 32'h8, 32'h0);
        chk("R8 irq off", {31'h0, bank_irq}, 32'h0);

        // R9 edge in the same cycle as the clear
        setpin(11, 1'b1);
        @(posedge clk); @(posedge clk);
        wr(ad(7, 1, 0), 32'h08);
        settle();
        rd(ad(4, 1, 0), d); chk("R9 edge beats clear", d & 32'h8, 32'h8);
        wr(ad(7, 1, 0), 32'h08); settle();
        rd(ad(4, 1, 0), d); chk("R9 later clear", d & 32'h8, 32'h0);
        setpin(11, 1'b0); settle();
        rd(ad(4, 1, 0), d); chk("R5 rising ignores fall", d & 32'h8, 32'h0);
        wr(ad(5, 1, 0), 32'h0);

        // R5 falling edge, port2 pin0 (bit 16)
        wr(ad(6, 2, 0), 32'h000100);
        setpin(16, 1'b1); settle();
        wr(ad(7, 2, 0), 32'hFF); settle();
        rd(ad(4, 2, 0), d); chk("R5 falling ignores rise", d & 32'h1, 32'h0);
        setpin(16, 1'b0); settle();
        rd(ad(4, 2, 0), d); chk("R5 falling set", d & 32'h1, 32'h1);

        // R5 either edge, port3 pin7 (bit 31)
        wr(ad(6, 3, 0), 32'h808000);
        wr(ad(7, 3, 0), 32'hFF);
        setpin(31, 1'b1); settle();
        rd(ad(4, 3, 0), d); chk("R5 both rise", d & 32'h80, 32'h80);
        wr(ad(7, 3, 0), 32'h80); settle();
        rd(ad(4, 3, 0), d); chk("R5 both cleared", d & 32'h80, 32'h0);
        setpin(31, 1'b0); settle();
        rd(ad(4, 3, 0), d); chk("R5 both fall", d & 32'h80, 32'h80);
        chk("R8 status set but disabled", {31'h0, bank_irq}, 32'h0);
        wr(ad(5, 3, 0), 32'h80);
        chk("R8 enable raises irq", {31'h0, bank_irq}, 32'h1);
        wr(ad(5, 3, 0), 32'h0);
        wr(ad(7, 3, 0), 32'h80);

        // R6 level high, port0 pin1
        wr(ad(6, 0, 0), 32'h000002);
        wr(ad(5, 0, 0), 32'h02);
        setpin(1, 1'b1); settle();
        rd(ad(4, 0, 0), d); chk("R6 level high set", d & 32'h2, 32'h2);
        chk("R8 level irq", {31'h0, bank_irq}, 32'h1);
        wr(ad(7, 0, 0), 32'h02); settle();
        rd(ad(4, 0, 0), d); chk("R6 clear while active", d & 32'h2, 32'h2);
        setpin(1, 1'b0); settle();
        rd(ad(4, 0, 0), d); chk("R6 level high drops", d & 32'h2, 32'h0);
        chk("R8 level irq off", {31'h0, bank_irq}, 32'h0);
        // R6 level low, port0 pin2
        rd(ad(4, 0, 0), d); chk("R6 level low active", d & 32'h4, 32'h4);
        setpin(2, 1'b1); settle();
        rd(ad(4, 0, 0), d); chk("R6 level low inactive", d & 32'h4, 32'h0);
        setpin(2, 1'b0);
        wr(ad(5, 0, 0), 32'h0);

        // R10 status writes on port2 pin0 (falling edge type)
        wr(ad(7, 2, 0), 32'hFF);
        rd(ad(4, 2, 0), d); chk("R10 precleared", d & 32'h1, 32'h0);
        wr(ad(4, 2, 0), 32'h01);
        rd(ad(4, 2, 0), d); chk("R10 direct set", d & 32'h1, 32'h1);
        wr(ad(4, 2, 1), 32'h0100);
        rd(ad(4, 2, 0), d); chk("R10 masked clear", d & 32'h1, 32'h0);

        // R3 alias ignores clear group; type alias touches polarity byte only
        wr(ad(4, 2, 0), 32'h01);
        wr(ad(7, 2, 1), 32'hFFFF);
        rd(ad(4, 2, 0), d); chk("R3 alias clear ignored", d & 32'h1, 32'h1);
        wr(ad(6, 1, 1), 32'h0101);
        rd(ad(6, 1, 0), d); chk("R3 alias type polarity", d, 32'h000809);
        chk("R8 final irq", {31'h0, bank_irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule